// File: doc/BRIEF.md
# Pipeline hazard interlock unit

This block is the interlock and steering controller for an in-order integer pipeline with five stages: fetch, decode, operand read, execute and retire (writeback). It holds no data. Each cycle it looks at the source register fields of the instruction in operand read, at the destination fields and valid bits of the older instructions in execute and retire, and at the branch outcome from execute. From these it drives hold enables for the front stages, a bubble into execute, squash enables for the wrong-path stages, and the select codes for the two execute operand multiplexers.

A static mode input chooses between interlock-only operation and bypassing. In interlock-only mode a dependent instruction waits in operand read until every older writer of its sources has left retire. In bypassing mode the execute operands are steered from the in-flight results. Only a producer that is marked late, meaning its value exists only once it reaches retire, still costs a single wait cycle. A second mode input makes branches delayed. In that mode the one instruction behind a taken branch survives instead of being squashed.

Operand read can be marked slow when it fetches an operand from memory. It then occupies a fixed number of cycles, and the block raises a busy indication and holds the stages upstream for the extra cycles.

Top module: `hazard_ctl`

## Requirements
- R1: After reset, with no valid instruction in any stage, every hold, bubble, squash and busy output is 0 and both select codes are 00.
- R2: With bypassing off, an operand-read instruction that uses a source equal to the destination of a valid, writing instruction in execute or retire raises `hold_rd`, `hold_fe`, `hold_de` and `bubble_ex`, and both select codes stay 00.
- R3: Source register 0 never causes a hold and never gets a select code other than 00.
- R4: With bypassing on, a match against a non-late execute producer gives select 01 with no hold, and a match against retire only gives select 10. When both match, 01 (the younger producer) wins.
- R5: With bypassing on, a match against a late execute producer holds operand read for that cycle, and both select codes read 00 whenever `hold_rd` is 1.
- R6: A source whose use bit is 0, a producer whose valid or write-enable is 0, or an invalid operand-read stage creates no dependency.
- R7: A taken branch in a valid execute stage raises `squash_fe`, `squash_de` and `squash_rd` in the same cycle. A squash overrides the hold of the same stage, and a branch flag with execute invalid does nothing.
- R8: With delayed branches on, a taken branch squashes fetch and decode only. `squash_rd` stays 0 and the operand-read instruction is kept.
- R9: A slow operand-read instruction raises `opnd_busy` and holds upstream for exactly OPF_LAT-1 cycles starting with its first cycle in operand read, then releases. A squash of operand read drops `opnd_busy` at once and restarts the count for the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| byp_mode | input | 1 | 1 enables operand bypassing |
| dly_br_mode | input | 1 | 1 keeps the instruction behind a taken branch |
| rd_vld | input | 1 | Operand-read stage holds a valid instruction |
| rd_src1 | input | REG_AW | First source register of the operand-read instruction |
| rd_src1_use | input | 1 | First source is read |
| rd_src2 | input | REG_AW | Second source register |
| rd_src2_use | input | 1 | Second source is read |
| rd_slow | input | 1 | Operand read fetches from memory (multi-cycle) |
| ex_vld | input | 1 | Execute stage valid |
| ex_dst | input | REG_AW | Execute destination register |
| ex_wr | input | 1 | Execute instruction writes its destination |
| ex_late | input | 1 | Execute result only available at retire |
| ex_br_taken | input | 1 | Execute instruction is a branch resolved taken |
| rt_vld | input | 1 | Retire stage valid |
| rt_dst | input | REG_AW | Retire destination register |
| rt_wr | input | 1 | Retire instruction writes its destination |
| hold_fe | output | 1 | Hold fetch |
| hold_de | output | 1 | Hold decode |
| hold_rd | output | 1 | Hold operand read |
| bubble_ex | output | 1 | Load an invalid slot into execute |
| squash_fe | output | 1 | Clear fetch valid |
| squash_de | output | 1 | Clear decode valid |
| squash_rd | output | 1 | Clear operand-read valid |
| opnd_sel1 | output | 2 | Source 1 steering: 00 register file, 01 execute result, 10 retire result |
| opnd_sel2 | output | 2 | Source 2 steering, same encoding |
| opnd_busy | output | 1 | Multi-cycle operand fetch in progress |

## Verification
The hardest situation to reach is a taken branch that lands while a slow operand fetch is part way through its count. The squash must end the busy phase in that very cycle and reset the count, so the next slow instruction again waits the full time. The stimulus starts a slow fetch, raises the branch one cycle later, and then presents a fresh slow instruction and times its busy window. Combined cases also get dedicated table rows: both producers matching one source, each source steered from a different stage, and a late producer in bypass mode.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_EXEC    = 2'b01,
    SRC_RETIRE  = 2'b10
  } opnd_src_e;

  // Steering choice: the youngest matching producer wins.
  function automatic opnd_src_e pick_source(input logic hit_ex, input logic hit_rt);
    if (hit_ex)      return SRC_EXEC;
    else if (hit_rt) return SRC_RETIRE;
    else             return SRC_REGFILE;
  endfunction

  // Whether a single operand must wait in operand read.
  function automatic logic operand_waits(input logic byp, input logic hit_ex,
                                         input logic ex_late, input logic hit_rt);
    if (byp) return hit_ex & ex_late;
    else     return hit_ex | hit_rt;
  endfunction

endpackage

// File: rtl/hz_raw_detect.sv
module hz_raw_detect
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              byp_mode,
  input  logic              rd_vld,
  input  logic [REG_AW-1:0] src,
  input  logic              src_use,
  input  logic              ex_vld,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wr,
  input  logic              ex_late,
  input  logic              rt_vld,
  input  logic [REG_AW-1:0] rt_dst,
  input  logic              rt_wr,
  output logic              waits,
  output opnd_src_e         sel
);
  logic live_src;
  logic hit_ex;
  logic hit_rt;

  assign live_src = rd_vld & src_use & (src != '0);
  assign hit_ex   = live_src & ex_vld & ex_wr & (ex_dst == src);
  assign hit_rt   = live_src & rt_vld & rt_wr & (rt_dst == src);

  always_comb begin
    waits = operand_waits(byp_mode, hit_ex, ex_late, hit_rt);
    if (byp_mode && !waits) sel = pick_source(hit_ex, hit_rt);
    else                    sel = SRC_REGFILE;
  end
endmodule

// File: rtl/hz_opf_timer.sv
module hz_opf_timer #(
  parameter int OPF_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic clear,
  output logic busy
);
  generate
    if (OPF_LAT <= 1) begin : g_single
      assign busy = 1'b0;
    end else begin : g_multi
      localparam int CW = $clog2(OPF_LAT);
      localparam logic [CW-1:0] LAST = CW'(OPF_LAT - 1);
      logic [CW-1:0] cnt_q;

      assign busy = req & (cnt_q != LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else if (busy)  cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/hz_branch_flush.sv
module hz_branch_flush (
  input  logic ex_vld,
  input  logic ex_br_taken,
  input  logic dly_br_mode,
  output logic squash_fe,
  output logic squash_de,
  output logic squash_rd
);
  logic redirect;
  assign redirect  = ex_vld & ex_br_taken;
  assign squash_fe = redirect;
  assign squash_de = redirect;
  assign squash_rd = redirect & ~dly_br_mode;
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hz_pkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int OPF_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byp_mode,
  input  logic              dly_br_mode,
  input  logic              rd_vld,
  input  logic [REG_AW-1:0] rd_src1,
  input  logic              rd_src1_use,
  input  logic [REG_AW-1:0] rd_src2,
  input  logic              rd_src2_use,
  input  logic              rd_slow,
  input  logic              ex_vld,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wr,
  input  logic              ex_late,
  input  logic              ex_br_taken,
  input  logic              rt_vld,
  input  logic [REG_AW-1:0] rt_dst,
  input  logic              rt_wr,
  output logic              hold_fe,
  output logic              hold_de,
  output logic              hold_rd,
  output logic              bubble_ex,
  output logic              squash_fe,
  output logic              squash_de,
  output logic              squash_rd,
  output logic [1:0]        opnd_sel1,
  output logic [1:0]        opnd_sel2,
  output logic              opnd_busy
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_AW-1:0] src_reg;
  logic [NSRC-1:0]             src_use;
  logic [NSRC-1:0]             src_wait;
  opnd_src_e                   src_sel [NSRC];

  // Named internal events, visible to the checker.
  logic data_wait;
  logic fetch_busy_raw;
  logic rd_advance;

  assign src_reg[0] = rd_src1;
  assign src_reg[1] = rd_src2;
  assign src_use[0] = rd_src1_use;
  assign src_use[1] = rd_src2_use;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      hz_raw_detect #(.REG_AW(REG_AW)) u_raw (
        .byp_mode (byp_mode),
        .rd_vld   (rd_vld),
        .src      (src_reg[g]),
        .src_use  (src_use[g]),
        .ex_vld   (ex_vld),
        .ex_dst   (ex_dst),
        .ex_wr    (ex_wr),
        .ex_late  (ex_late),
        .rt_vld   (rt_vld),
        .rt_dst   (rt_dst),
        .rt_wr    (rt_wr),
        .waits    (src_wait[g]),
        .sel      (src_sel[g])
      );
    end
  endgenerate

  hz_branch_flush u_br (
    .ex_vld      (ex_vld),
    .ex_br_taken (ex_br_taken),
    .dly_br_mode (dly_br_mode),
    .squash_fe   (squash_fe),
    .squash_de   (squash_de),
    .squash_rd   (squash_rd)
  );

  hz_opf_timer #(.OPF_LAT(OPF_LAT)) u_opf (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (rd_vld & rd_slow),
    .clear (rd_advance),
    .busy  (fetch_busy_raw)
  );

  assign data_wait  = |src_wait;
  assign hold_rd    = rd_vld & (data_wait | fetch_busy_raw) & ~squash_rd;
  assign rd_advance = ~hold_rd;
  assign hold_de    = hold_rd & ~squash_de;
  assign hold_fe    = hold_rd & ~squash_fe;
  assign bubble_ex  = hold_rd;
  assign opnd_busy  = fetch_busy_raw & ~squash_rd;
  assign opnd_sel1  = hold_rd ? SRC_REGFILE : src_sel[0];
  assign opnd_sel2  = hold_rd ? SRC_REGFILE : src_sel[1];
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int REG_AW  = 5,
  parameter int OPF_LAT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byp_mode,
  input logic              dly_br_mode,
  input logic [REG_AW-1:0] rd_src1,
  input logic [REG_AW-1:0] rd_src2,
  input logic              hold_fe,
  input logic              hold_de,
  input logic              hold_rd,
  input logic              bubble_ex,
  input logic              squash_fe,
  input logic              squash_de,
  input logic              squash_rd,
  input logic [1:0]        opnd_sel1,
  input logic [1:0]        opnd_sel2,
  input logic              opnd_busy
);
  logic [31:0] busy_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_run_q <= '0;
    else if (opnd_busy) busy_run_q <= busy_run_q + 1;
    else                busy_run_q <= '0;
  end

  assert_upstream_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rd |-> (hold_de || squash_de) && (hold_fe || squash_fe) && bubble_ex);

  assert_no_steer_interlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !byp_mode |-> (opnd_sel1 == 2'b00) && (opnd_sel2 == 2'b00));

  assert_zero_src1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_src1 == '0) |-> (opnd_sel1 == 2'b00));

  assert_zero_src2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_src2 == '0) |-> (opnd_sel2 == 2'b00));

  assert_sel_idle_on_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rd |-> (opnd_sel1 == 2'b00) && (opnd_sel2 == 2'b00));

  assert_squash_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    squash_rd |-> !hold_rd && !opnd_busy && squash_de && squash_fe);

  assert_delay_slot_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dly_br_mode |-> !squash_rd);

  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_busy |-> hold_rd);

  assert_busy_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_busy |-> (busy_run_q < 32'(OPF_LAT - 1)));
endmodule

bind hazard_ctl hazard_ctl_chk #(.REG_AW(REG_AW), .OPF_LAT(OPF_LAT)) chk_i (.*);

// File: tb/hazard_ctl_tb_top.sv
module hazard_ctl_tb_top;
  localparam int AW  = 5;
  localparam int LAT = 3;

  typedef struct packed {
    logic          byp;
    logic          dly;
    logic          rv;
    logic [AW-1:0] s1;
    logic          u1;
    logic [AW-1:0] s2;
    logic          u2;
    logic          ev;
    logic [AW-1:0] ed;
    logic          ew;
    logic          el;
    logic          eb;
    logic          tv;
    logic [AW-1:0] td;
    logic          tw;
    logic          x_hold;
    logic          x_sqf;
    logic          x_sqd;
    logic          x_sqr;
    logic [1:0]    x_s1;
    logic [1:0]    x_s2;
    logic [3:0]    req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    // R2: interlock, src1 matches execute
    '{1'b0,1'b0,1'b1,5'd3,1'b1,5'd1,1'b1, 1'b1,5'd3,1'b1,1'b0,1'b0, 1'b0,5'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,2'd0,2'd0, 4'd2},
    // R2: interlock, src2 matches retire
    '{1'b0,1'b0,1'b1,5'd2,1'b1,5'd4,1'b1, 1'b1,5'd9,1'b1,1'b0,1'b0, 1'b1,5'd4,1'b1, 1'b1,1'b0,1'b0,1'b0,2'd0,2'd0, 4'd2},
    // R3: register 0, interlock mode
    '{1'b0,1'b0,1'b1,5'd0,1'b1,5'd0,1'b1, 1'b1,5'd0,1'b1,1'b0,1'b0, 1'b1,5'd0,1'b1, 1'b0,1'b0,1'b0,1'b0,2'd0,2'd0, 4'd3},
    // R3: register 0, bypass mode
    '{1'b1,1'b0,1'b1,5'd0,1'b1,5'd0,1'b1, 1'b1,5'd0,1'b1,1'b0,1'b0, 1'b1,5'd0,1'b1, 1'b0,1'b0,1'b0,1'b0,2'd0,2'd0, 4'd3},
    // R4: bypass from execute
    '{1'b1,1'b0,1'b1,5'd5,1'b1,5'd1,1'b1, 1'b1,5'd5,1'b1,1'b0,1'b0, 1'b0,5'd0,1'b0, 1'b0,1'b0,1'b0,1'b0,2'd1,2'd0, 4'd4},
    // R4: bypass from retire
    '{1'b1,1'b0,1'b1,5'd2,1'b1,5'd6,1'b1, 1'b1,5'd9,1'b1,1'b0,1'b0, 1'b1,5'd6,1'b1, 1'b0,1'b0,1'b0,1'b0,2'd0,2'd2, 4'd4},
    // R4: both match, younger wins
    '{1'b1,1'b0,1'b1,5'd7,1'b1,5'd7,1'b1, 1'b1,5'd7,1'b1,1'b0,1'b0, 1'b1,5'd7,1'b1, 1'b0,1'b0,1'b0,1'b0,2'd1,2'd1, 4'd4},
    // R4: each source from a different stage
    '{1'b1,1'b0,1'b1,5'd4,1'b1,5'd5,1'b1, 1'b1,5'd5,1'b1,1'b0,1'b0, 1'b1,5'd4,1'b1, 1'b0,1'b0,1'b0,1'b0,2'd2,2'd1, 4'd4},
    // R5: late execute producer still waits
    '{1'b1,1'b0,1'b1,5'd8,1'b1,5'd8,1'b1, 1'b1,5'd8,1'b1,1'b1,1'b0, 1'b0,5'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,2'd0,2'd0, 4'd5},
    // R6: unused sources
    '{1'b0,1'b0,1'b1,5'd9,1'b0,5'd1,1'b0, 1'b1,5'd9,1'b1,1'b0,1'b0, 1'b1,5'd1,1'b1, 1'b0,1'b0,1'b0,1'b0,2'd0,2'd0, 4'd6},
    // R6: non-writing execute, invalid retire
    '{1'b0,1'b0,1'b1,5'd10,1'b1,5'd1,1'b1, 1'b1,5'd10,1'b0,1'b0,1'b0, 1'b0,5'd1,1'b1, 1'b0,1'b0,1'b0,1'b0,2'd0,2'd0, 4'd6},
    // R6: operand read invalid
    '{1'b1,1'b0,1'b0,5'd11,1'b1,5'd11,1'b1, 1'b1,5'd11,1'b1,1'b1,1'b0, 1'b1,5'd11,1'b1, 1'b0,1'b0,1'b0,1'b0,2'd0,2'd0, 4'd6},
    // R7: taken branch squashes three stages and overrides a hold
    '{1'b0,1'b0,1'b1,5'd12,1'b1,5'd0,1'b0, 1'b1,5'd12,1'b1,1'b0,1'b1, 1'b0,5'd0,1'b0, 1'b0,1'b1,1'b1,1'b1,2'd0,2'd0, 4'd7},
    // R7: branch in bypass mode
    '{1'b1,1'b0,1'b1,5'd3,1'b1,5'd0,1'b0, 1'b1,5'd13,1'b1,1'b0,1'b1, 1'b0,5'd0,1'b0, 1'b0,1'b1,1'b1,1'b1,2'd0,2'd0, 4'd7},
    // R8: delayed branch keeps operand read
    '{1'b0,1'b1,1'b1,5'd2,1'b1,5'd0,1'b0, 1'b1,5'd14,1'b1,1'b0,1'b1, 1'b0,5'd0,1'b0, 1'b0,1'b1,1'b1,1'b0,2'd0,2'd0, 4'd8},
    // R7: branch flag with execute invalid
    '{1'b0,1'b0,1'b1,5'd2,1'b1,5'd0,1'b0, 1'b0,5'd14,1'b1,1'b0,1'b1, 1'b0,5'd0,1'b0, 1'b0,1'b0,1'b0,1'b0,2'd0,2'd0, 4'd7}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic byp_mode, dly_br_mode, rd_vld, rd_src1_use, rd_src2_use, rd_slow;
  logic [AW-1:0] rd_src1, rd_src2, ex_dst, rt_dst;
  logic ex_vld, ex_wr, ex_late, ex_br_taken, rt_vld, rt_wr;
  logic hold_fe, hold_de, hold_rd, bubble_ex, squash_fe, squash_de, squash_rd, opnd_busy;
  logic [1:0] opnd_sel1, opnd_sel2;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int cycles = 0;

  always #2.5ns clk = ~clk;

  hazard_ctl #(.REG_AW(AW), .OPF_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .byp_mode(byp_mode), .dly_br_mode(dly_br_mode),
    .rd_vld(rd_vld), .rd_src1(rd_src1), .rd_src1_use(rd_src1_use),
    .rd_src2(rd_src2), .rd_src2_use(rd_src2_use), .rd_slow(rd_slow),
    .ex_vld(ex_vld), .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_late(ex_late),
    .ex_br_taken(ex_br_taken), .rt_vld(rt_vld), .rt_dst(rt_dst), .rt_wr(rt_wr),
    .hold_fe(hold_fe), .hold_de(hold_de), .hold_rd(hold_rd), .bubble_ex(bubble_ex),
    .squash_fe(squash_fe), .squash_de(squash_de), .squash_rd(squash_rd),
    .opnd_sel1(opnd_sel1), .opnd_sel2(opnd_sel2), .opnd_busy(opnd_busy)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    byp_mode = 0; dly_br_mode = 0; rd_vld = 0; rd_src1 = '0; rd_src1_use = 0;
    rd_src2 = '0; rd_src2_use = 0; rd_slow = 0; ex_vld = 0; ex_dst = '0; ex_wr = 0;
    ex_late = 0; ex_br_taken = 0; rt_vld = 0; rt_dst = '0; rt_wr = 0;
  endtask

  task automatic apply(input vec_t v);
    byp_mode = v.byp; dly_br_mode = v.dly; rd_vld = v.rv; rd_slow = 0;
    rd_src1 = v.s1; rd_src1_use = v.u1; rd_src2 = v.s2; rd_src2_use = v.u2;
    ex_vld = v.ev; ex_dst = v.ed; ex_wr = v.ew; ex_late = v.el; ex_br_taken = v.eb;
    rt_vld = v.tv; rt_dst = v.td; rt_wr = v.tw;
  endtask

  function automatic logic [31:0] pack_out();
    return {19'd0, hold_fe, hold_de, hold_rd, bubble_ex, squash_fe, squash_de,
            squash_rd, opnd_sel1, opnd_sel2, opnd_busy};
  endfunction

  function automatic logic [31:0] pack_exp(input logic h, input logic sf, input logic sd,
                                           input logic sr, input logic [1:0] a,
                                           input logic [1:0] b, input logic busy);
    // hold_fe/hold_de follow hold_rd unless their own stage is squashed
    return {19'd0, h & ~sf, h & ~sd, h, h, sf, sd, sr, a, b, busy};
  endfunction

  task automatic step_and_check(input string req, input logic busy, input logic h,
                                input logic sf, input logic sr);
    #1ns;
    check(req, pack_out(), pack_exp(h, sf, sf, sr, 2'd0, 2'd0, busy));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1ns;
    check("R1 in reset", pack_out(), 32'd0);
    rst_n = 1;
    @(negedge clk);
    #1ns;
    check("R1 after reset", pack_out(), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      apply(VEC[i]);
      #1ns;
      check($sformatf("R%0d vector %0d", VEC[i].req, i), pack_out(),
            pack_exp(VEC[i].x_hold, VEC[i].x_sqf, VEC[i].x_sqd, VEC[i].x_sqr,
                     VEC[i].x_s1, VEC[i].x_s2, 1'b0));
    end

    // R9: slow operand fetch, full window
    @(negedge clk);
    idle_inputs();
    rd_vld = 1; rd_slow = 1;
    step_and_check("R9 busy cycle 1", 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    step_and_check("R9 busy cycle 2", 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    step_and_check("R9 released", 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rd_vld = 0; rd_slow = 0;
    step_and_check("R9 idle", 1'b0, 1'b0, 1'b0, 1'b0);

    // R9 with R7: squash during the busy window restarts the count
    @(negedge clk);
    rd_vld = 1; rd_slow = 1;
    step_and_check("R9 second start", 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    ex_vld = 1; ex_br_taken = 1;
    step_and_check("R9 squash ends busy", 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    ex_vld = 0; ex_br_taken = 0;
    step_and_check("R9 restart cycle 1", 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    step_and_check("R9 restart cycle 2", 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    step_and_check("R9 restart released", 1'b0, 1'b0, 1'b0, 1'b0);

    // R8 with R9: delayed branch keeps a busy slow fetch held
    @(negedge clk);
    rd_vld = 0; rd_slow = 0;
    @(negedge clk);
    rd_vld = 1; rd_slow = 1; dly_br_mode = 1; ex_vld = 1; ex_br_taken = 1;
    #1ns;
    check("R8 slot kept during busy", pack_out(),
          pack_exp(1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b1));

    @(negedge clk);
    idle_inputs();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule